// File: doc/BRIEF.md
# Match-Compare Timer Counter

A free-running peripheral timer with one compare channel. A programmable prescaler divides the peripheral clock. Each time the prescaler wraps, the timer counter advances by one. When the counter equals the compare value at one of these advances, a match event fires. Three action bits decide what that event does: latch an interrupt flag, send the counter back to zero, and/or switch counting off. Setting interrupt plus zeroing gives a periodic tick. Setting stop plus zeroing gives a one-shot delay.

Software reaches the block through a small single-cycle register port. A write takes effect at the clock edge where the write strobe is high. A read is a combinational decode of the address. The port has no back-pressure: every access completes in the cycle it is presented. The interrupt output follows the latched match flag, which software clears by writing a one.

Top module: `mct_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Control register (word 0) bit 0 enables counting and bit 1 holds both the prescaler and the counter at zero while set, whatever the enable says. With the enable low and the hold bit low, the counter keeps its value.
- R3: With prescale value P (word 1), the counter advances once every P+1 enabled clocks. With P = 0 it advances on every clock.
- R4: A match event occurs when the counter would advance while it equals the compare value (word 3). Action register (word 4) bit 0 = latch flag, bit 1 = zero counter, bit 2 = stop. Without bit 0 set, no flag is latched.
- R5: With the zero action, the counter goes to 0 in place of advancing. The period is therefore (compare+1)*(P+1) clocks.
- R6: The stop action clears control bit 0 (readable back). The counter then holds: it stays at the compare value, or at 0 if the zero action is also set. A hardware clear of the enable wins over a software control write in the same cycle.
- R7: Flag register (word 5) bit 0 is write-one-to-clear. Writing 0 there has no effect. A hardware set in the same cycle as a clear leaves the flag set.
- R8: `irq` equals the latched match flag.
- R9: Word 2 reads the live counter value and ignores writes. Words 6 and 7 read zero. Register writes land at the strobe's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Match interrupt, high while the flag is pending |

## Verification
The bench measures the exact period between interrupts with and without prescaling. An off-by-one in the wrap or zeroing logic would show up as a period of compare or compare+2 ticks. It runs one-shot and stop-only matches and checks where the counter rests and that the enable reads back cleared. A design that kept counting, or that zeroed the counter without the zero action, would fail there. It writes a flag clear in the very cycle of a new match, where a design that let the clear win would lose an interrupt. It also checks that writing zeros to the flag register changes nothing. A behavioural model is compared on every clock, so the hold bit, the freeze while disabled, and ignored counter writes are checked throughout the run.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MAT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ACT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLG  = 3'd5;

  // packed so that bit 0 = flag, bit 1 = zero, bit 2 = stop
  typedef struct packed {
    logic stop;
    logic zero;
    logic flag;
  } act_t;
endpackage

// File: rtl/mct_regs.sv
module mct_regs
  import mct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              match_ev,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  rdata,
  output logic              en,
  output logic              hold,
  output logic [CNT_W-1:0]  prescale,
  output logic [CNT_W-1:0]  match_val,
  output act_t              act,
  output logic              flag
);
  logic wr_ctrl, wr_pre, wr_mat, wr_act, wr_flg;
  logic hw_set;

  assign wr_ctrl = wr && (addr == A_CTRL);
  assign wr_pre  = wr && (addr == A_PRE);
  assign wr_mat  = wr && (addr == A_MAT);
  assign wr_act  = wr && (addr == A_ACT);
  assign wr_flg  = wr && (addr == A_FLG);
  assign hw_set  = match_ev && act.flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      hold      <= 1'b0;
      prescale  <= '0;
      match_val <= '0;
      act       <= '0;
      flag      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en   <= wdata[0];
        hold <= wdata[1];
      end
      if (match_ev && act.stop) en <= 1'b0;
      if (wr_pre) prescale  <= wdata;
      if (wr_mat) match_val <= wdata;
      if (wr_act) act       <= act_t'(wdata[2:0]);
      if (hw_set)                  flag <= 1'b1;
      else if (wr_flg && wdata[0]) flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[1:0] = {hold, en};
      A_PRE:   rdata = prescale;
      A_CNT:   rdata = count;
      A_MAT:   rdata = match_val;
      A_ACT:   rdata[2:0] = act;
      A_FLG:   rdata[0] = flag;
      default: rdata = '0;
    endcase
  end

  // R6
  stop_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && act.stop) |=> !en);
  // R7
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag);
  // R7
  flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flg && wdata[0] && !hw_set) |=> !flag);
endmodule

// File: rtl/mct_prescaler.sv
module mct_prescaler #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hold,
  input  logic [CNT_W-1:0] prescale,
  output logic             tick
);
  logic [CNT_W-1:0] pcnt;
  logic             wrap;

  assign wrap = (pcnt >= prescale);
  assign tick = en && !hold && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pcnt <= '0;
    else if (hold)  pcnt <= '0;
    else if (en)    pcnt <= wrap ? '0 : pcnt + 1'b1;
  end

  // R2
  pre_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (pcnt == '0));
endmodule

// File: rtl/mct_counter.sv
module mct_counter
  import mct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  input  logic [CNT_W-1:0] match_val,
  input  act_t             act,
  output logic [CNT_W-1:0] count,
  output logic             match_ev
);
  assign match_ev = tick && (count == match_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (hold)                  count <= '0;
    else if (match_ev && act.zero)  count <= '0;
    else if (match_ev && act.stop)  count <= count;
    else if (tick)                  count <= count + 1'b1;
  end

  // R2
  cnt_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (count == '0));
  // R2
  cnt_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hold) |=> $stable(count));
  // R3
  cnt_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !match_ev) |=> (count == CNT_W'($past(count) + 1'b1)));
  // R5
  cnt_zero_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && act.zero) |=> (count == '0));
endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);
  logic             en, hold, tick, match_ev, flag;
  logic [CNT_W-1:0] prescale, match_val, count;
  act_t             act;

  mct_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .match_ev(match_ev), .count(count), .rdata(reg_rdata), .en(en), .hold(hold),
    .prescale(prescale), .match_val(match_val), .act(act), .flag(flag)
  );

  mct_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .hold(hold), .prescale(prescale), .tick(tick)
  );

  mct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hold(hold), .tick(tick), .match_val(match_val),
    .act(act), .count(count), .match_ev(match_ev)
  );

  assign irq = flag;

  // R8
  irq_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && act.flag) |=> irq);
endmodule

// File: tb/tb_mct_timer.sv
module tb_mct_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference state
  bit          m_en, m_hold, m_flag;
  logic [31:0] m_pc, m_tc, m_pre, m_mat;
  logic [2:0]  m_act;

  always #(CLK_P/2) clk = ~clk;

  mct_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act_v,
                       input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act_v, exp_v, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: m_read = {30'd0, m_hold, m_en};
      3'd1: m_read = m_pre;
      3'd2: m_read = m_tc;
      3'd3: m_read = m_mat;
      3'd4: m_read = {29'd0, m_act};
      3'd5: m_read = {31'd0, m_flag};
      default: m_read = 32'd0;
    endcase
  endfunction

  // reference model step, on the same edge as the design
  always @(posedge clk) begin
    bit tick, ev;
    logic [31:0] n_pc, n_tc;
    bit n_en, n_hold, n_flag;
    cyc++;
    if (!rst_n) begin
      m_en = 0; m_hold = 0; m_flag = 0;
      m_pc = 0; m_tc = 0; m_pre = 0; m_mat = 0; m_act = 0;
    end else begin
      tick = m_en && !m_hold && (m_pc >= m_pre);
      ev   = tick && (m_tc == m_mat);
      if (m_hold) n_pc = 0;
      else if (m_en) n_pc = (m_pc >= m_pre) ? 0 : m_pc + 1;
      else n_pc = m_pc;
      if (m_hold) n_tc = 0;
      else if (ev && m_act[1]) n_tc = 0;
      else if (ev && m_act[2]) n_tc = m_tc;
      else if (tick) n_tc = m_tc + 1;
      else n_tc = m_tc;
      n_en = m_en; n_hold = m_hold; n_flag = m_flag;
      if (reg_wr && reg_addr == 3'd0) begin n_en = reg_wdata[0]; n_hold = reg_wdata[1]; end
      if (ev && m_act[2]) n_en = 0;
      if (ev && m_act[0]) n_flag = 1;
      else if (reg_wr && reg_addr == 3'd5 && reg_wdata[0]) n_flag = 0;
      if (reg_wr && reg_addr == 3'd1) m_pre = reg_wdata;
      if (reg_wr && reg_addr == 3'd3) m_mat = reg_wdata;
      if (reg_wr && reg_addr == 3'd4) m_act = reg_wdata[2:0];
      m_pc = n_pc; m_tc = n_tc; m_en = n_en; m_hold = n_hold; m_flag = n_flag;
    end
  end

  // compare a quarter period after each edge
  always @(posedge clk) begin
    #(CLK_P/4);
    check(irq === m_flag, "R8 irq vs model", {31'd0, irq}, {31'd0, m_flag});
    check(reg_rdata === m_read(reg_addr), "R9 read vs model", reg_rdata, m_read(reg_addr));
  end

  // tasks start and end at a negedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(output int at);
    int guard = 0;
    while (!irq && guard < 1000) begin @(negedge clk); guard++; end
    at = cyc;
  endtask

  bit wd_hit = 0;
  initial begin
    #(CLK_P * 150000);
    wd_hit = 1;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int t0, t1;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: all registers zero after reset
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v);
      check(v == 0, "R1 reset value", v, 0);
    end
    check(irq == 0, "R1 irq low", {31'd0, irq}, 0);

    // R5: periodic, compare 4, prescale 0 -> 5 clocks
    wr(3'd1, 0); wr(3'd3, 4); wr(3'd4, 3); wr(3'd0, 2); wr(3'd0, 1);
    wait_irq(t0); wr(3'd5, 1);
    idle(1);
    wait_irq(t1); wr(3'd5, 1);
    check(t1 - t0 == 5, "R5 period", t1 - t0, 5);

    // R3: prescale 2 -> 15 clocks
    wr(3'd0, 2); wr(3'd1, 2); wr(3'd5, 1); wr(3'd0, 1);
    wait_irq(t0); wr(3'd5, 1);
    idle(1);
    wait_irq(t1); wr(3'd5, 1);
    check(t1 - t0 == 15, "R3 prescaled period", t1 - t0, 15);

    // R6: one-shot (zero + stop), R4: no flag without flag action
    wr(3'd0, 2); wr(3'd5, 1); wr(3'd1, 0); wr(3'd3, 3); wr(3'd4, 6); wr(3'd0, 1);
    idle(10);
    rd(3'd0, v); check(v == 0, "R6 enable cleared one-shot", v, 0);
    rd(3'd2, v); check(v == 0, "R6 one-shot rests at zero", v, 0);
    rd(3'd5, v); check(v == 0, "R4 no flag without action", v, 0);

    // R6: stop-only holds at compare value; R4 flag latched
    wr(3'd0, 2); wr(3'd3, 6); wr(3'd4, 5); wr(3'd0, 1);
    idle(15);
    rd(3'd2, v); check(v == 6, "R6 stop holds compare", v, 6);
    rd(3'd0, v); check(v == 0, "R6 enable cleared stop", v, 0);
    rd(3'd5, v); check(v == 1, "R4 flag latched", v, 1);

    // R7: write zero ignored, write one clears
    wr(3'd5, 0);
    rd(3'd5, v); check(v == 1, "R7 zero write ignored", v, 1);
    wr(3'd5, 1);
    rd(3'd5, v); check(v == 0, "R7 w1c", v, 0);
    check(irq == 0, "R8 irq drops", {31'd0, irq}, 0);

    // R2: hold bit overrides enable
    wr(3'd0, 3); idle(5);
    rd(3'd2, v); check(v == 0, "R2 hold keeps zero", v, 0);
    // R2: disabled counter freezes
    wr(3'd4, 0); wr(3'd3, 32'hFFFF_0000); wr(3'd0, 1); idle(7);
    wr(3'd0, 0);
    rd(3'd2, v); idle(5); rd(3'd2, v2);
    check(v == v2 && v != 0, "R2 freeze when disabled", v2, v);

    // R9: counter write ignored, unused words read zero
    wr(3'd2, 32'h1234);
    rd(3'd2, v2); check(v2 == v, "R9 count write ignored", v2, v);
    rd(3'd7, v); check(v == 0, "R9 unused word", v, 0);

    // R7: set in the same cycle as clear wins
    wr(3'd1, 0); wr(3'd3, 5); wr(3'd4, 1); wr(3'd0, 2); wr(3'd0, 1);
    idle(5);
    wr(3'd5, 1);
    rd(3'd5, v); check(v == 1, "R7 set beats clear", v, 1);

    idle(3);
    if (!wd_hit) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule